// File: doc/BRIEF.md
# Host Word Exchange Port

This block is a slave port through which an external host processor trades 16-bit words with a DSP core. The host sees three registers. A status word reports the two handshake flags. A transmit word is filled by the core and read by the host. A receive word is filled by the host and drained by the core. The host drives active-low chip-select, read and write strobes, two address lines and a data bus. A mode input sets the bus width to 8 or 16 bits. In 8-bit mode, one 16-bit word moves as two byte accesses.

The host pins are asynchronous to the core clock. The three strobes pass through a two-flop synchroniser. Address and data are sampled only while a strobe is held, so they are stable when captured. A host access state machine has four states:
- `HP_IDLE`: waits for a strobe.
- `HP_READ`: holds while the read strobe is active. On release it emits a read-done pulse and returns to `HP_IDLE`.
- `HP_WRITE`: lasts one cycle and emits the write commit.
- `HP_WAIT`: holds until the write strobe is released, then returns to `HP_IDLE`.

The transitions are:
- `HP_IDLE`→`HP_READ` on a synchronised read strobe with chip select. Read wins if both strobes are seen.
- `HP_IDLE`→`HP_WRITE` on a synchronised write strobe with chip select.
- `HP_READ`→`HP_IDLE` when the strobe is released.
- `HP_WRITE`→`HP_WAIT` unconditionally.
- `HP_WAIT`→`HP_IDLE` when the strobe is released.

The register address and the write data are latched on leaving `HP_IDLE`. The bus drivers are modelled as per-lane output enables.

Top module: `host_xfer_port`

## Requirements
- R1: After reset, the host read-ready flag is 0, the host write-ready flag is 1, `core_tx_empty` is 1, `core_rx_ready` is 0 and `host_d_oe` is 0.
- R2: A core write while the transmit word is empty loads it and raises the host read-ready flag. A core write while it is full is ignored, and the held word is kept.
- R3: With `host_a1`=1, a host read returns the status word: bit 0 = read-ready, bit 1 = write-ready, all other bits 0. A host write with `host_a1`=1 changes nothing.
- R4: In 16-bit mode (`host_mode16`=1), a read with `host_a1`=0 returns the whole transmit word, ignoring `host_a0`. The read-ready flag clears once that read's strobe is released.
- R5: In 8-bit mode, the addressed word's byte appears on `host_d_out[7:0]`: bits 15:8 when `host_a0`=1, bits 7:0 when `host_a0`=0. `host_d_out[15:8]` is 0.
- R6: In 8-bit mode, reading the transmit low byte (`host_a0`=0) leaves read-ready set. Reading the high byte (`host_a0`=1) clears it.
- R7: In 16-bit mode, a host write with `host_a1`=0 loads all 16 receive bits, ignoring `host_a0`. It clears write-ready and sets `core_rx_ready`.
- R8: In 8-bit mode, a host write with `host_a0`=0 loads receive bits 7:0 from `host_d_in[7:0]` and leaves write-ready set. A write with `host_a0`=1 loads bits 15:8 and completes the word.
- R9: A host write to the receive word while it is full is ignored.
- R10: A `core_rx_rd` pulse while the receive word is full sets write-ready again. A pulse while it is empty has no effect.
- R11: `host_d_oe` is 0 unless `host_cs_n` and `host_rd_n` are both low. Then bit 0 is 1, and bit 1 is 1 only in 16-bit mode.
- R12: A host write takes effect at the fourth rising clock edge after its strobe falls. A read's completion takes effect at the third rising edge after its strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| host_mode16 | input | 1 | 1 = 16-bit host bus, 0 = 8-bit |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_a1 | input | 1 | 1 = status word, 0 = data words |
| host_a0 | input | 1 | Byte lane in 8-bit mode (1 = high byte) |
| host_d_in | input | 16 | Host write data |
| host_d_out | output | 16 | Host read data |
| host_d_oe | output | 2 | Output enable, bit 0 low lane, bit 1 high lane |
| host_rdy_rd | output | 1 | Transmit word holds unread data |
| host_rdy_wr | output | 1 | Receive word is empty |
| core_tx_wr | input | 1 | Core write pulse for the transmit word |
| core_tx_data | input | 16 | Core transmit data |
| core_tx_empty | output | 1 | Transmit word may be loaded |
| core_rx_rd | input | 1 | Core acknowledge of the receive word |
| core_rx_data | output | 16 | Receive word |
| core_rx_ready | output | 1 | Receive word is full |

## Verification
Read data and the output enables follow the pins combinationally, so the bench samples them several cycles into a held strobe. Flag effects are due later:
- A write becomes visible at the fourth rising edge after the strobe falls: two synchroniser stages, the `HP_WRITE` state, then the register update.
- A read completion becomes visible at the third rising edge after the strobe rises.
- Core-side writes and acknowledges act on the next edge.

The bench holds every strobe and every release for six cycles, so all these edges have passed before it samples. A directed test samples on each side of the due edge for both the write and the read-completion case, to confirm the exact latency.

// File: rtl/hport_pkg.sv
package hport_pkg;
    typedef enum logic [1:0] {
        HP_IDLE  = 2'd0,
        HP_READ  = 2'd1,
        HP_WRITE = 2'd2,
        HP_WAIT  = 2'd3
    } hp_state_t;

    typedef struct packed {
        logic a1;
        logic a0;
        logic m16;
    } hp_addr_t;
endpackage

// File: rtl/hport_sync.sv
module hport_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[s] <= '1;
                end else if (s == 0) begin
                    chain[s] <= async_in;
                end else begin
                    chain[s] <= chain[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hport_fsm.sv
module hport_fsm
    import hport_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_cs_n,
    input  logic              s_rd_n,
    input  logic              s_wr_n,
    input  logic              a1,
    input  logic              a0,
    input  logic              mode16,
    input  logic [DATA_W-1:0] d_in,
    output logic              rd_done,
    output logic              wr_commit,
    output hp_addr_t          lat_addr,
    output logic [DATA_W-1:0] lat_data
);
    hp_state_t state, state_nx;
    logic rd_act, wr_act;

    assign rd_act = !s_cs_n && !s_rd_n;
    assign wr_act = !s_cs_n && !s_wr_n;

    always_comb begin
        state_nx = state;
        unique case (state)
            HP_IDLE: begin
                if (rd_act)      state_nx = HP_READ;
                else if (wr_act) state_nx = HP_WRITE;
            end
            HP_READ:  if (!rd_act) state_nx = HP_IDLE;
            HP_WRITE: state_nx = HP_WAIT;
            HP_WAIT:  if (!wr_act) state_nx = HP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= HP_IDLE;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            state <= state_nx;
            if (state == HP_IDLE && state_nx != HP_IDLE) begin
                lat_addr <= '{a1: a1, a0: a0, m16: mode16};
                lat_data <= d_in;
            end
        end
    end

    always_comb begin
        rd_done   = 1'b0;
        wr_commit = 1'b0;
        unique case (state)
            HP_IDLE:  ;
            HP_READ:  rd_done = !rd_act;
            HP_WRITE: wr_commit = 1'b1;
            HP_WAIT:  ;
        endcase
    end

    assert_pulse_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_done && wr_commit));
    assert_commit_once_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> !wr_commit);
endmodule

// File: rtl/hport_regs.sv
module hport_regs
    import hport_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_done,
    input  logic              wr_commit,
    input  hp_addr_t          acc,
    input  logic [DATA_W-1:0] wdata,
    input  logic              core_tx_wr,
    input  logic [DATA_W-1:0] core_tx_data,
    input  logic              core_rx_rd,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_full,
    output logic [DATA_W-1:0] rx_word,
    output logic              rx_full
);
    localparam int LANE_W = DATA_W / 2;

    logic tx_take, tx_finish, rx_put, rx_last;

    assign tx_take   = core_tx_wr && !tx_full;
    assign tx_finish = rd_done && !acc.a1 && tx_full && (acc.m16 || acc.a0);
    assign rx_put    = wr_commit && !acc.a1 && !rx_full;
    assign rx_last   = acc.m16 || acc.a0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_word <= '0;
            tx_full <= 1'b0;
        end else if (tx_take) begin
            tx_word <= core_tx_data;
            tx_full <= 1'b1;
        end else if (tx_finish) begin
            tx_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_word <= '0;
            rx_full <= 1'b0;
        end else if (rx_put) begin
            if (acc.m16)
                rx_word <= wdata;
            else if (acc.a0)
                rx_word[DATA_W-1:LANE_W] <= wdata[LANE_W-1:0];
            else
                rx_word[LANE_W-1:0] <= wdata[LANE_W-1:0];
            rx_full <= rx_last;
        end else if (core_rx_rd && rx_full) begin
            rx_full <= 1'b0;
        end
    end

    assert_core_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_tx_wr && !tx_full |=> tx_full && tx_word == $past(core_tx_data));
    assert_core_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_tx_wr && tx_full |=> $stable(tx_word));
    assert_low_byte_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done && tx_full && !acc.m16 && !acc.a0 |=> tx_full);
    assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit && rx_full |=> $stable(rx_word));
    assert_rx_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(core_rx_rd));
endmodule

// File: rtl/host_xfer_port.sv
module host_xfer_port
    import hport_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_mode16,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_a1,
    input  logic              host_a0,
    input  logic [DATA_W-1:0] host_d_in,
    output logic [DATA_W-1:0] host_d_out,
    output logic [1:0]        host_d_oe,
    output logic              host_rdy_rd,
    output logic              host_rdy_wr,
    input  logic              core_tx_wr,
    input  logic [DATA_W-1:0] core_tx_data,
    output logic              core_tx_empty,
    input  logic              core_rx_rd,
    output logic [DATA_W-1:0] core_rx_data,
    output logic              core_rx_ready
);
    localparam int LANE_W = DATA_W / 2;

    logic [2:0]        strobes_s;
    logic              rd_done, wr_commit;
    hp_addr_t          lat_addr;
    logic [DATA_W-1:0] lat_data, tx_word, rx_word, status_word, sel_word;
    logic              tx_full, rx_full, read_on;

    hport_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_cs_n, host_rd_n, host_wr_n}),
        .sync_out (strobes_s)
    );

    hport_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_cs_n    (strobes_s[2]),
        .s_rd_n    (strobes_s[1]),
        .s_wr_n    (strobes_s[0]),
        .a1        (host_a1),
        .a0        (host_a0),
        .mode16    (host_mode16),
        .d_in      (host_d_in),
        .rd_done   (rd_done),
        .wr_commit (wr_commit),
        .lat_addr  (lat_addr),
        .lat_data  (lat_data)
    );

    hport_regs #(.DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_done      (rd_done),
        .wr_commit    (wr_commit),
        .acc          (lat_addr),
        .wdata        (lat_data),
        .core_tx_wr   (core_tx_wr),
        .core_tx_data (core_tx_data),
        .core_rx_rd   (core_rx_rd),
        .tx_word      (tx_word),
        .tx_full      (tx_full),
        .rx_word      (rx_word),
        .rx_full      (rx_full)
    );

    assign status_word = {{(DATA_W-2){1'b0}}, !rx_full, tx_full};
    assign sel_word    = host_a1 ? status_word : tx_word;
    assign read_on     = !host_cs_n && !host_rd_n;

    always_comb begin
        if (host_mode16)
            host_d_out = sel_word;
        else if (host_a0)
            host_d_out = {{LANE_W{1'b0}}, sel_word[DATA_W-1:LANE_W]};
        else
            host_d_out = {{LANE_W{1'b0}}, sel_word[LANE_W-1:0]};
    end

    assign host_d_oe     = {read_on && host_mode16, read_on};
    assign host_rdy_rd   = tx_full;
    assign host_rdy_wr   = !rx_full;
    assign core_tx_empty = !tx_full;
    assign core_rx_ready = rx_full;
    assign core_rx_data  = rx_word;

    assert_oe_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_cs_n |-> host_d_oe == 2'b00);
    assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
        core_tx_empty != host_rdy_rd);
endmodule

// File: tb/host_xfer_port_test.sv
module host_xfer_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_mode16 = 1'b1, host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1;
    logic        host_a1 = 1'b0, host_a0 = 1'b0;
    logic [15:0] host_d_in = '0, host_d_out, core_tx_data = '0, core_rx_data;
    logic [1:0]  host_d_oe;
    logic        host_rdy_rd, host_rdy_wr, core_tx_wr = 1'b0, core_tx_empty;
    logic        core_rx_rd = 1'b0, core_rx_ready;
    int          n_run = 0, n_fail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    host_xfer_port uut (.*);

    typedef struct packed {
        logic [1:0]  kind;   // 0 core tx write, 1 host read, 2 host write, 3 core rx read
        logic        m16;
        logic        a1;
        logic        a0;
        logic [15:0] data;
        logic [15:0] expv;
    } vec_t;

    localparam vec_t VEC [0:21] = '{
        '{2'd0, 1'b1, 1'b0, 1'b0, 16'hA55A, 16'h0000}, // R2 load
        '{2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0003}, // R3 status both flags
        '{2'd1, 1'b1, 1'b0, 1'b1, 16'h0000, 16'hA55A}, // R4 word read, a0 ignored
        '{2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0002}, // R4 cleared
        '{2'd2, 1'b1, 1'b0, 1'b1, 16'h1234, 16'h0000}, // R7 word write
        '{2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0000}, // R7 write-ready low
        '{2'd3, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h1234}, // R7 core sees word
        '{2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0002}, // R10 write-ready again
        '{2'd0, 1'b1, 1'b0, 1'b0, 16'hC3E1, 16'h0000}, // R2 load
        '{2'd1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h00E1}, // R5 low byte
        '{2'd1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0003}, // R6 still ready
        '{2'd1, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h00C3}, // R5 high byte
        '{2'd1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0002}, // R6 cleared
        '{2'd2, 1'b0, 1'b0, 1'b0, 16'hFF77, 16'h0000}, // R8 low byte write
        '{2'd1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0002}, // R8 not complete
        '{2'd2, 1'b0, 1'b0, 1'b1, 16'h0088, 16'h0000}, // R8 high byte write
        '{2'd1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h0000}, // R8 complete
        '{2'd2, 1'b1, 1'b0, 1'b0, 16'hDEAD, 16'h0000}, // R9 write while full
        '{2'd3, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h8877}, // R9 R8 word kept
        '{2'd2, 1'b1, 1'b1, 1'b0, 16'hFFFF, 16'h0000}, // R3 status write
        '{2'd1, 1'b1, 1'b1, 1'b0, 16'h0000, 16'h0002}, // R3 unchanged
        '{2'd1, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h0000}  // R3 status upper byte zero
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic host_read(input logic m16, input logic a1, input logic a0, output logic [15:0] got);
        @(negedge clk);
        host_mode16 = m16; host_a1 = a1; host_a0 = a0;
        host_cs_n = 1'b0; host_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        got = host_d_out;
        host_cs_n = 1'b1; host_rd_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic host_write(input logic m16, input logic a1, input logic a0, input logic [15:0] d);
        @(negedge clk);
        host_mode16 = m16; host_a1 = a1; host_a0 = a0; host_d_in = d;
        host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (6) @(negedge clk);
        host_cs_n = 1'b1; host_wr_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic core_write(input logic [15:0] d);
        @(negedge clk);
        core_tx_wr = 1'b1; core_tx_data = d;
        @(negedge clk);
        core_tx_wr = 1'b0;
    endtask

    task automatic core_read(output logic [15:0] got);
        @(negedge clk);
        got = core_rx_data;
        core_rx_rd = 1'b1;
        @(negedge clk);
        core_rx_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdy_rd", {15'd0, host_rdy_rd}, 16'd0);
        check("R1 rdy_wr", {15'd0, host_rdy_wr}, 16'd1);
        check("R1 tx_empty", {15'd0, core_tx_empty}, 16'd1);
        check("R1 rx_ready", {15'd0, core_rx_ready}, 16'd0);
        check("R1 oe", {14'd0, host_d_oe}, 16'd0);

        for (int i = 0; i < 22; i++) begin
            unique case (VEC[i].kind)
                2'd0: core_write(VEC[i].data);
                2'd1: begin
                    host_read(VEC[i].m16, VEC[i].a1, VEC[i].a0, got);
                    check($sformatf("vec%0d host read", i), got, VEC[i].expv);
                end
                2'd2: host_write(VEC[i].m16, VEC[i].a1, VEC[i].a0, VEC[i].data);
                2'd3: begin
                    core_read(got);
                    check($sformatf("vec%0d core read", i), got, VEC[i].expv);
                end
            endcase
        end

        // R2 core write while full is ignored
        core_write(16'h1111);
        core_write(16'h2222);
        host_read(1'b1, 1'b0, 1'b0, got);
        check("R2 write while full ignored", got, 16'h1111);

        // R10 core read while empty has no effect
        core_read(got);
        check("R10 empty ack no effect", {15'd0, host_rdy_wr}, 16'd1);

        // R11 output enables by mode
        @(negedge clk);
        host_mode16 = 1'b0; host_a1 = 1'b1; host_cs_n = 1'b0; host_rd_n = 1'b0;
        #1 check("R11 oe 8-bit", {14'd0, host_d_oe}, 16'd1);
        host_mode16 = 1'b1;
        #1 check("R11 oe 16-bit", {14'd0, host_d_oe}, 16'd3);
        host_cs_n = 1'b1;
        #1 check("R11 oe no select", {14'd0, host_d_oe}, 16'd0);
        host_rd_n = 1'b1;
        repeat (6) @(negedge clk);

        // R12 write latency
        host_mode16 = 1'b1; host_a1 = 1'b0; host_d_in = 16'h5A5A;
        host_cs_n = 1'b0; host_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 write before fourth edge", {15'd0, host_rdy_wr}, 16'd1);
        @(negedge clk);
        check("R12 write at fourth edge", {15'd0, host_rdy_wr}, 16'd0);
        host_cs_n = 1'b1; host_wr_n = 1'b1;
        repeat (6) @(negedge clk);
        core_read(got);
        check("R7 latency word", got, 16'h5A5A);

        // R12 read completion latency
        core_write(16'h0F0F);
        @(negedge clk);
        host_a1 = 1'b0; host_cs_n = 1'b0; host_rd_n = 1'b0;
        repeat (6) @(negedge clk);
        check("R4 flag held during strobe", {15'd0, host_rdy_rd}, 16'd1);
        host_cs_n = 1'b1; host_rd_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R12 read before third edge", {15'd0, host_rdy_rd}, 16'd1);
        @(negedge clk);
        check("R12 read at third edge", {15'd0, host_rdy_rd}, 16'd0);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule